// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block carries a continuous stream of fixed-width words from one clock domain to another when the two clocks have no phase or frequency relationship. The producer side pushes a word on any write-clock edge where its enable is high and the buffer is not full. The consumer side sees the oldest stored word on its data output whenever the buffer is not empty, and pops it by raising its enable for one read-clock edge. Storage is a register array with 2^ADDR entries, written in the write domain and read in the read domain.

Each side counts its own transfers with a binary counter one bit wider than the address, and registers a Gray-coded copy of that count. Only the Gray copy crosses to the other domain, through a two-stage synchronizer that covers the whole word. A Gray count changes in one bit per step, so the far side always sees either the true count or the one before it. Because of this lag the flags are conservative: full and empty may stay set a few cycles longer than strictly needed, but a word is never overwritten or read twice.

Top module: `dcf_fifo`

## Requirements
- R1: After both resets have been held low for at least two edges of their own clock, `rd_empty` is 1 and `wr_full` is 0.
- R2: Words appear on `rd_data` in exactly the order they were accepted on the write side, each once; `rd_data` shows the oldest stored word while `rd_empty` is 0.
- R3: A write attempted while `wr_full` is 1 is discarded: it changes neither the stored words nor the write count, so after the buffer drains exactly 2^ADDR words come out and none carries the discarded data.
- R4: A read attempted while `rd_empty` is 1 is discarded: the read count does not move, so the next word written is the next word read.
- R5: With the read side idle and its count already seen by the write side, `wr_full` goes to 1 on the same write-clock edge that accepts the 2^ADDR-th stored word, and is still 0 after the word before it.
- R6: When the write side is idle and its count already seen by the read side, `rd_empty` goes to 1 on the same read-clock edge that pops the last stored word.
- R7: After a word is written into an empty buffer, `rd_empty` falls within four rising edges of `rd_clk` that follow the write edge.
- R8: After a word is popped from a full buffer, `wr_full` falls within four rising edges of `wr_clk` that follow the read edge.
- R9: Each side's registered Gray pointer changes in at most one bit per edge of its clock; with both sides transferring at the same time across more than two wraps of the counters, every word arrives once and in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain synchronous reset, active low |
| wr_en | input | 1 | Push request; taken only while `wr_full` is 0 |
| wr_data | input | DW | Word to push |
| wr_full | output | 1 | Buffer has no free entry as seen from the write side |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain synchronous reset, active low |
| rd_en | input | 1 | Pop request; taken only while `rd_empty` is 0 |
| rd_data | output | DW | Oldest stored word |
| rd_empty | output | 1 | No stored word as seen from the read side |

## Verification
The two functions that meet in one cycle are a push and a pop: in the streaming scenario the faster write clock keeps the buffer at the full boundary, so push attempts that are rejected by `wr_full` land in the same window as pops that free an entry, and the slower side's flag is still stale. The scenario is judged only by what leaves the read port: a running expected sequence computed in the bench must match every popped word across several counter wraps, so any lost, duplicated or overwritten word shows up as a mismatch. The flag-latency checks bound the stale window from the other direction by counting clock edges until the flag clears.

// File: rtl/dcf_pkg.sv
// Package shared by the dual-clock FIFO blocks.
// Holds the synchronizer depth and the binary-to-Gray conversion.
package dcf_pkg;

    // Number of flops each crossing pointer passes through.
    localparam int SYNC_STAGES = 2;

    // Binary to Gray: adjacent values differ in exactly one bit.
    // Callers widen to 32 bits and truncate the result back.
    function automatic logic [31:0] to_gray(input logic [31:0] bin);
        return bin ^ (bin >> 1);
    endfunction

endpackage

// File: rtl/dcf_sync.sv
// Multi-stage synchronizer for a word that changes in at most one bit
// per source edge (a Gray pointer). Assumes the input comes straight
// from a register in the source domain. Synchronous active-low reset.
module dcf_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    import dcf_pkg::*;

    logic [W-1:0] stage [SYNC_STAGES];

    // Shift the far-domain word through the resolution chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[SYNC_STAGES-1];

endmodule

// File: rtl/dcf_mem.sv
// Register-array storage: one write port clocked by the write domain,
// one unclocked read port addressed from the read domain. The read
// side only uses the output while its pointer trails the write pointer.
module dcf_mem #(
    parameter int DW   = 8,
    parameter int ADDR = 3
) (
    input  logic            wclk,
    input  logic            we,
    input  logic [ADDR-1:0] waddr,
    input  logic [DW-1:0]   wdata,
    input  logic [ADDR-1:0] raddr,
    output logic [DW-1:0]   rdata
);
    localparam int DEPTH = 1 << ADDR;

    logic [DW-1:0] cells [DEPTH];

    // Store the pushed word at the write address.
    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/dcf_wr_ctrl.sv
// Write-side pointer and full flag. Keeps a binary count ADDR+1 bits
// wide plus its registered Gray copy; the top bit marks the wrap and is
// not part of the address. Full is registered from the next pointer so
// it moves on the same edge as the pointer. Assumes ADDR >= 2.
module dcf_wr_ctrl #(
    parameter int ADDR = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [ADDR:0]   rgray_sync,
    output logic            wr_fire,
    output logic [ADDR-1:0] waddr,
    output logic [ADDR:0]   wgray,
    output logic            full
);
    import dcf_pkg::*;

    localparam int PW = ADDR + 1;

    logic [ADDR:0] wbin;
    logic [ADDR:0] wbin_next;
    logic [ADDR:0] wgray_next;
    logic [ADDR:0] full_match;

    // Gate the push and form the next count, its Gray code and the
    // far pointer with its two top bits flipped.
    always_comb begin
        wr_fire    = wr_en & ~full;
        wbin_next  = wbin + PW'(wr_fire);
        wgray_next = PW'(to_gray(32'(wbin_next)));
        full_match = {~rgray_sync[ADDR:ADDR-1], rgray_sync[ADDR-2:0]};
    end

    // Advance the pointer pair and register the full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
            full  <= 1'b0;
        end else begin
            wbin  <= wbin_next;
            wgray <= wgray_next;
            full  <= (wgray_next == full_match);
        end
    end

    assign waddr = wbin[ADDR-1:0];

    // R3: a push against a full buffer leaves the write address alone.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> $stable(waddr));

    // R5: full can only appear after a push was requested.
    p_full_after_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(wr_en));

    // R9: the crossing Gray word moves in at most one bit per edge.
    p_wgray_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));

endmodule

// File: rtl/dcf_rd_ctrl.sv
// Read-side pointer and empty flag. Mirrors the write side: binary
// count ADDR+1 bits wide with a registered Gray copy. Empty is
// registered from the next pointer and compares it with the
// synchronized write pointer. Empty resets high.
module dcf_rd_ctrl #(
    parameter int ADDR = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  logic [ADDR:0]   wgray_sync,
    output logic [ADDR-1:0] raddr,
    output logic [ADDR:0]   rgray,
    output logic            empty
);
    import dcf_pkg::*;

    localparam int PW = ADDR + 1;

    logic [ADDR:0] rbin;
    logic [ADDR:0] rbin_next;
    logic [ADDR:0] rgray_next;
    logic          rd_fire;

    // Gate the pop and form the next count and its Gray code.
    always_comb begin
        rd_fire    = rd_en & ~empty;
        rbin_next  = rbin + PW'(rd_fire);
        rgray_next = PW'(to_gray(32'(rbin_next)));
    end

    // Advance the pointer pair and register the empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
            empty <= 1'b1;
        end else begin
            rbin  <= rbin_next;
            rgray <= rgray_next;
            empty <= (rgray_next == wgray_sync);
        end
    end

    assign raddr = rbin[ADDR-1:0];

    // R4: a pop against an empty buffer leaves the read address alone.
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> $stable(raddr));

    // R6: empty can only return after a pop was requested.
    p_empty_after_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(empty) |-> $past(rd_en));

    // R9: the crossing Gray word moves in at most one bit per edge.
    p_rgray_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(rgray ^ $past(rgray)) <= 1));

endmodule

// File: rtl/dcf_fifo.sv
// Dual-clock FIFO top. Connects the two pointer controllers, the two
// pointer synchronizers and the storage array. Each reset is synchronous
// to its own clock and active low; both must be applied together.
module dcf_fifo #(
    parameter int DW   = 8,
    parameter int ADDR = 3
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          wr_full,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_empty
);
    localparam int PW = ADDR + 1;

    logic            wr_fire;
    logic [ADDR-1:0] waddr;
    logic [ADDR-1:0] raddr;
    logic [PW-1:0]   wgray;
    logic [PW-1:0]   rgray;
    logic [PW-1:0]   wgray_in_rd;
    logic [PW-1:0]   rgray_in_wr;

    dcf_wr_ctrl #(.ADDR(ADDR)) u_wr (
        .clk        (wr_clk),
        .rst_n      (wr_rst_n),
        .wr_en      (wr_en),
        .rgray_sync (rgray_in_wr),
        .wr_fire    (wr_fire),
        .waddr      (waddr),
        .wgray      (wgray),
        .full       (wr_full)
    );

    dcf_rd_ctrl #(.ADDR(ADDR)) u_rd (
        .clk        (rd_clk),
        .rst_n      (rd_rst_n),
        .rd_en      (rd_en),
        .wgray_sync (wgray_in_rd),
        .raddr      (raddr),
        .rgray      (rgray),
        .empty      (rd_empty)
    );

    dcf_sync #(.W(PW)) u_w2r (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wgray),
        .q     (wgray_in_rd)
    );

    dcf_sync #(.W(PW)) u_r2w (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (rgray),
        .q     (rgray_in_wr)
    );

    dcf_mem #(.DW(DW), .ADDR(ADDR)) u_mem (
        .wclk  (wr_clk),
        .we    (wr_fire),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (rd_data)
    );

endmodule

// File: tb/dcf_fifo_tb.sv
`timescale 1ns/100ps
module dcf_fifo_tb;
    localparam int DW    = 8;
    localparam int ADDR  = 3;
    localparam int DEPTH = 1 << ADDR;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0;
    logic          rd_rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          wr_full;
    logic          rd_empty;

    int n_run  = 0;
    int n_fail = 0;

    dcf_fifo #(.DW(DW), .ADDR(ADDR)) u_dut (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_full  (wr_full),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_empty (rd_empty)
    );

    // 200 MHz write clock, unrelated 7 ns read clock with a phase offset.
    always #2.5 wr_clk = ~wr_clk;
    initial begin
        #1.3;
        forever #3.5 rd_clk = ~rd_clk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(posedge wr_clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic pop_expect(input logic [DW-1:0] exp, input string req);
        int guard = 0;
        @(negedge rd_clk);
        while (rd_empty && guard < 20) begin
            @(negedge rd_clk);
            guard++;
        end
        chk(!rd_empty && rd_data == exp, req, int'(rd_data), int'(exp));
        rd_en = 1'b1;
        @(posedge rd_clk);
        #1 rd_en = 1'b0;
    endtask

    // R1: flags after reset.
    task automatic t_reset();
        #1;
        chk(rd_empty == 1'b1, "R1 empty", int'(rd_empty), 1);
        chk(wr_full == 1'b0, "R1 full", int'(wr_full), 0);
    endtask

    // R5, R3, R2, R6: fill, attempt overflow, drain.
    task automatic t_fill_overflow();
        for (int i = 0; i < DEPTH; i++) begin
            push(DW'(8'h10 + i));
            if (i == DEPTH - 2) chk(wr_full == 1'b0, "R5 not full early", int'(wr_full), 0);
        end
        chk(wr_full == 1'b1, "R5 full on last push", int'(wr_full), 1);
        @(negedge wr_clk);
        wr_en = 1'b1;
        wr_data = 8'hEE;
        repeat (3) @(negedge wr_clk);
        wr_en = 1'b0;
        chk(wr_full == 1'b1, "R3 still full", int'(wr_full), 1);
        for (int i = 0; i < DEPTH; i++) pop_expect(DW'(8'h10 + i), "R2/R3 drain order");
        chk(rd_empty == 1'b1, "R6 empty on last pop", int'(rd_empty), 1);
        repeat (8) @(negedge rd_clk);
        chk(rd_empty == 1'b1, "R3 no extra word", int'(rd_empty), 1);
    endtask

    // R4: pops while empty must not move the read pointer.
    task automatic t_underflow();
        @(negedge rd_clk);
        rd_en = 1'b1;
        repeat (5) @(negedge rd_clk);
        rd_en = 1'b0;
        chk(rd_empty == 1'b1, "R4 empty held", int'(rd_empty), 1);
        push(8'h5A);
        pop_expect(8'h5A, "R4 next word after underflow");
        repeat (6) @(negedge rd_clk);
        chk(rd_empty == 1'b1, "R4 empty again", int'(rd_empty), 1);
    endtask

    // R7: empty clears within four read edges of a write.
    task automatic t_empty_latency();
        int n = 0;
        push(8'hA7);
        while (rd_empty && n < 10) begin
            @(posedge rd_clk);
            #1 n++;
        end
        chk(n >= 1 && n <= 4, "R7 empty release edges", n, 3);
        pop_expect(8'hA7, "R7 data");
        repeat (6) @(negedge rd_clk);
    endtask

    // R8: full clears within four write edges of a pop.
    task automatic t_full_latency();
        int n = 0;
        for (int i = 0; i < DEPTH; i++) push(DW'(8'h40 + i));
        repeat (4) @(negedge wr_clk);
        pop_expect(8'h40, "R8 first word");
        while (wr_full && n < 10) begin
            @(posedge wr_clk);
            #1 n++;
        end
        chk(n >= 1 && n <= 4, "R8 full release edges", n, 3);
        for (int i = 1; i < DEPTH; i++) pop_expect(DW'(8'h40 + i), "R8 drain");
        repeat (8) @(negedge wr_clk);
    endtask

    // R9, R2: concurrent push and pop across several wraps.
    task automatic t_stream();
        localparam int N = 5 * DEPTH + 3;
        int errs = 0;
        int first_bad = 0;
        int first_exp = 0;
        fork
            begin
                for (int i = 0; i < N; i++) begin
                    @(negedge wr_clk);
                    while (wr_full) @(negedge wr_clk);
                    wr_en   = 1'b1;
                    wr_data = DW'(i * 3 + 1);
                    @(posedge wr_clk);
                    #1 wr_en = 1'b0;
                end
            end
            begin
                for (int i = 0; i < N; i++) begin
                    @(negedge rd_clk);
                    while (rd_empty) @(negedge rd_clk);
                    if (rd_data != DW'(i * 3 + 1)) begin
                        if (errs == 0) begin
                            first_bad = int'(rd_data);
                            first_exp = int'(DW'(i * 3 + 1));
                        end
                        errs++;
                    end
                    rd_en = 1'b1;
                    @(posedge rd_clk);
                    #1 rd_en = 1'b0;
                end
            end
        join
        chk(errs == 0, "R9 stream order", first_bad, first_exp);
        repeat (6) @(negedge rd_clk);
        chk(rd_empty == 1'b1, "R9 stream drained", int'(rd_empty), 1);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #400us;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(posedge rd_clk);
        @(negedge wr_clk);
        wr_rst_n = 1'b1;
        @(negedge rd_clk);
        rd_rst_n = 1'b1;
        t_reset();
        t_fill_overflow();
        t_underflow();
        t_empty_latency();
        t_full_latency();
        t_stream();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule